// File: doc/BRIEF.md
# L1 Line Coherence Controller

This block is the coherence state machine for a single line of a private first-level cache in a multicore system whose shared second-level cache keeps a directory and blocks while a transfer completes. It tracks the four stable MESI states plus a not-present state. It also tracks the transient states of an outstanding read miss, write miss, upgrade and writeback, including two race states. One covers an invalidation that overtakes shared read data. The other absorbs a writeback acknowledgement that arrives after the line has already been handed to another core.

Each cycle the surrounding cache presents at most one decoded event. It is either a processor access (load, instruction fetch, store, replacement) or a network message (invalidation, forwarded read, forwarded instruction read, forwarded exclusive read or upgrade, data, exclusive data, ack, writeback ack). One cycle later the block answers with one-cycle pulses:

- an outgoing request, a response and an unblock, each with a type code and a destination tag;
- a queue pop or recycle for the input queue the event came from;
- load or store completion;
- line allocate or free;
- an error pulse when the event is not legal in the current state.

The access permission of the line is derived from its state. Storage, tags and the network are outside the block.

Top module: `l1_line_coh`

## Requirements
- R1: After reset the state output is I (state codes: NP=0, I=1, S=2, E=3, M=4, IS=5, IM=6, SM=7, IS_I=8, M_I=9, E_I=10, SINK_WB_ACK=11), and every pulse output is low.
- R2: Permission (0 invalid, 1 read-only, 2 read-write, 3 busy) is invalid in NP and I, read-only in S and E, read-write in M, and busy in every transient state.
- R3: A processor event (kind 0 load, 1 ifetch, 2 store, 3 replacement) in any transient state pulses the recycle output, sends no request and leaves the state unchanged.
- R4: From NP or I, a load issues GETS (request type 0), an ifetch issues GET_INSTR (1), both entering IS, and a store issues GETX (2) entering IM. An invalidation (kind 4) there is answered with an ack response (type 1) to the sender and keeps the state.
- R5: A store in S issues UPGRADE (3) and enters SM. A store in E moves to M without a request, completes the store and sets the dirty flag.
- R6: A replacement in E or M issues PUTX (4) carrying the dirty flag, frees the line and enters M_I. A writeback ack (kind 12) in M_I returns to I.
- R7: In M_I, a forwarded exclusive read (kind 7, or upgrade kind 8) sends buffered data to the requestor only. A forwarded read (5) or instruction read (6) sends it to both requestor and L2. Both enter SINK_WB_ACK, which acks invalidations and leaves only on a writeback ack, to I.
- R8: In E or M, a forwarded exclusive read sends data (type 0) to the requestor and goes to I. A forwarded read or instruction read sends data to both requestor and L2 and goes to S.
- R9: An invalidation in IS or IS_I enters IS_I with an ack. Data (kind 9) from another L1 completes the load with a plain unblock and ends in S from IS or I from IS_I. Exclusive data (kind 10) completes the load, ends in E and sends an exclusive unblock.
- R10: In IM, data carries the count of acks still owed, and each ack (kind 11) retires one. Data that settles the count completes the store, sends an exclusive unblock and enters M; otherwise it enters SM. The ack that settles the count in SM does the same. An invalidation in IM or SM acks and enters IM.
- R11: Every request, L2-bound response and unblock names the L2 bank given by the address bits starting at the block-offset width, BANK_BITS wide.
- R12: An event kind that is not legal in the current state pulses the error output, leaves the state unchanged and pops no queue. At most one queue action or error is signalled per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_addr | input | ADDR_W | Byte address of the line |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 4 | Event kind code |
| ev_src | input | ID_W | Sender or requestor tag of a network event |
| ev_from_l1 | input | 1 | Data came from another L1 |
| ev_acks | input | ACK_W | Acks still owed, carried by data |
| ev_dirty | input | 1 | Dirty flag carried by data |
| state | output | 4 | Current line state code |
| perm | output | 2 | Access permission code |
| dirty | output | 1 | Line holds modified data |
| tbe_busy | output | 1 | Transaction buffer in use |
| req_valid | output | 1 | Request pulse |
| req_type | output | 3 | Request type code |
| req_dirty | output | 1 | Dirty flag on PUTX |
| req_bank | output | BANK_W | L2 bank of the request |
| rsp_valid | output | 1 | Response pulse |
| rsp_type | output | 1 | 0 data, 1 ack |
| rsp_to_req | output | 1 | Response goes to the requestor |
| rsp_dest | output | ID_W | Requestor tag |
| rsp_to_l2 | output | 1 | Response also goes to the L2 bank |
| rsp_bank | output | BANK_W | L2 bank of the response |
| rsp_from_tbe | output | 1 | Data taken from the transaction buffer |
| rsp_dirty | output | 1 | Dirty flag on the data |
| unb_valid | output | 1 | Unblock pulse |
| unb_excl | output | 1 | Unblock is exclusive |
| unb_bank | output | BANK_W | L2 bank of the unblock |
| pop_mand | output | 1 | Pop processor queue |
| recycle_mand | output | 1 | Recycle processor request |
| pop_req | output | 1 | Pop forwarded-request queue |
| pop_rsp | output | 1 | Pop response queue |
| ld_done | output | 1 | Load or ifetch completed |
| st_done | output | 1 | Store completed |
| line_alloc | output | 1 | Allocate the cache line |
| line_free | output | 1 | Free the cache line |
| err | output | 1 | Illegal event for the state |

## Verification
Two outputs land in the same cycle when a forwarded read hits a line in M, E or M_I. The data must then go to the requesting core and back to the L2 bank in one pulse, while the state moves to S or SINK_WB_ACK. The bench provokes this both from a resident modified line and from the writeback buffer. In each case it requires rsp_to_req and rsp_to_l2 high together, with the correct buffer source and bank. Against this it checks that a forwarded exclusive read raises only the requestor path. Completion and exclusive unblock also coincide when the final ack arrives; the bench orders acks both before and after the data to judge that.

// File: rtl/l1c_pkg.sv
package l1c_pkg;

    typedef enum logic [3:0] {
        ST_NP   = 4'd0,
        ST_I    = 4'd1,
        ST_S    = 4'd2,
        ST_E    = 4'd3,
        ST_M    = 4'd4,
        ST_IS   = 4'd5,
        ST_IM   = 4'd6,
        ST_SM   = 4'd7,
        ST_ISI  = 4'd8,
        ST_MI   = 4'd9,
        ST_EI   = 4'd10,
        ST_SINK = 4'd11
    } line_st_e;

    typedef enum logic [3:0] {
        EV_LOAD   = 4'd0,
        EV_IFETCH = 4'd1,
        EV_STORE  = 4'd2,
        EV_REPL   = 4'd3,
        EV_INV    = 4'd4,
        EV_FGETS  = 4'd5,
        EV_FGETI  = 4'd6,
        EV_FGETX  = 4'd7,
        EV_FUPG   = 4'd8,
        EV_DATA   = 4'd9,
        EV_DATAX  = 4'd10,
        EV_ACK    = 4'd11,
        EV_WBACK  = 4'd12
    } ev_kind_e;

    typedef enum logic [2:0] {
        RQ_GETS = 3'd0,
        RQ_GETI = 3'd1,
        RQ_GETX = 3'd2,
        RQ_UPG  = 3'd3,
        RQ_PUTX = 3'd4
    } req_e;

    typedef enum logic [1:0] {
        PM_INV  = 2'd0,
        PM_RO   = 2'd1,
        PM_RW   = 2'd2,
        PM_BUSY = 2'd3
    } perm_e;

    localparam logic RS_DATA = 1'b0;
    localparam logic RS_ACK  = 1'b1;

    typedef struct packed {
        logic req_v;
        req_e req_t;
        logic req_dirty;
        logic rsp_v;
        logic rsp_t;
        logic rsp_to_rq;
        logic rsp_to_l2;
        logic rsp_tbe;
        logic rsp_dirty;
        logic unb_v;
        logic unb_x;
        logic pop_m;
        logic rec_m;
        logic pop_q;
        logic pop_r;
        logic ld;
        logic st;
        logic alloc;
        logic free;
        logic err;
    } pulse_t;

    function automatic logic st_busy(line_st_e s);
        return !(s inside {ST_NP, ST_I, ST_S, ST_E, ST_M});
    endfunction

endpackage

// File: rtl/l1c_bank_sel.sv
module l1c_bank_sel #(
    parameter int ADDR_W      = 32,
    parameter int OFFSET_BITS = 6,
    parameter int BANK_BITS   = 2,
    parameter int BANK_W      = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank
);
    generate
        if (BANK_BITS == 0) begin : g_single
            assign bank = '0;
        end else begin : g_field
            assign bank = addr[OFFSET_BITS +: BANK_BITS];
        end
    endgenerate
endmodule

// File: rtl/l1c_perm_map.sv
module l1c_perm_map
    import l1c_pkg::*;
(
    input  line_st_e st,
    output perm_e    perm
);
    always_comb begin
        unique case (st)
            ST_NP, ST_I: perm = PM_INV;
            ST_S, ST_E:  perm = PM_RO;
            ST_M:        perm = PM_RW;
            default:     perm = PM_BUSY;
        endcase
    end
endmodule

// File: rtl/l1c_ack_tracker.sv
module l1c_ack_tracker #(
    parameter int ACK_W = 4,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_v,
    input  logic [ACK_W-1:0] add_n,
    input  logic             sub_v,
    output logic             data_all,
    output logic             ack_all
);
    logic signed [CNT_W-1:0] cnt_d, cnt_q;
    logic signed [CNT_W-1:0] n_ext, sum;
    localparam logic signed [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assign n_ext    = signed'({{(CNT_W-ACK_W){1'b0}}, add_n});
    assign sum      = cnt_q + n_ext;
    assign data_all = (sum == '0);
    assign ack_all  = (cnt_q == ONE);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)        cnt_d = '0;
        else if (add_v) cnt_d = sum;
        else if (sub_v) cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TRK_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(add_v && sub_v) && !(clr && (add_v || sub_v))); // R12
endmodule

// File: rtl/l1_line_coh.sv
module l1_line_coh
    import l1c_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int OFFSET_BITS = 6,
    parameter int BANK_BITS   = 2,
    parameter int ID_W        = 4,
    parameter int ACK_W       = 4,
    localparam int BANK_W     = (BANK_BITS > 0) ? BANK_BITS : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic              ev_valid,
    input  logic [3:0]        ev_kind,
    input  logic [ID_W-1:0]   ev_src,
    input  logic              ev_from_l1,
    input  logic [ACK_W-1:0]  ev_acks,
    input  logic              ev_dirty,
    output logic [3:0]        state,
    output logic [1:0]        perm,
    output logic              dirty,
    output logic              tbe_busy,
    output logic              req_valid,
    output logic [2:0]        req_type,
    output logic              req_dirty,
    output logic [BANK_W-1:0] req_bank,
    output logic              rsp_valid,
    output logic              rsp_type,
    output logic              rsp_to_req,
    output logic [ID_W-1:0]   rsp_dest,
    output logic              rsp_to_l2,
    output logic [BANK_W-1:0] rsp_bank,
    output logic              rsp_from_tbe,
    output logic              rsp_dirty,
    output logic              unb_valid,
    output logic              unb_excl,
    output logic [BANK_W-1:0] unb_bank,
    output logic              pop_mand,
    output logic              recycle_mand,
    output logic              pop_req,
    output logic              pop_rsp,
    output logic              ld_done,
    output logic              st_done,
    output logic              line_alloc,
    output logic              line_free,
    output logic              err
);
    localparam int CNT_W = ACK_W + 2;

    typedef struct packed {
        line_st_e        st;
        logic            dirty;
        logic            tdirty;
        logic            tbe;
        pulse_t          p;
        logic [ID_W-1:0] dest;
    } core_t;

    core_t    core_d, core_q;
    ev_kind_e kind;
    logic     is_proc, ill;
    logic     trk_clr, trk_add, trk_sub, data_all, ack_all;
    logic [BANK_W-1:0] bank;
    perm_e    perm_w;

    l1c_bank_sel #(
        .ADDR_W(ADDR_W), .OFFSET_BITS(OFFSET_BITS),
        .BANK_BITS(BANK_BITS), .BANK_W(BANK_W)
    ) u_bank (
        .addr(line_addr), .bank(bank)
    );

    l1c_perm_map u_perm (.st(core_q.st), .perm(perm_w));

    l1c_ack_tracker #(.ACK_W(ACK_W), .CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .clr(trk_clr), .add_v(trk_add),
        .add_n(ev_acks), .sub_v(trk_sub),
        .data_all(data_all), .ack_all(ack_all)
    );

    assign kind    = ev_kind_e'(ev_kind);
    assign is_proc = (ev_kind <= 4'd3);

    always_comb begin
        core_d   = core_q;
        core_d.p = '0;
        trk_clr  = 1'b0;
        trk_add  = 1'b0;
        trk_sub  = 1'b0;
        ill      = 1'b0;
        if (ev_valid) begin
            core_d.dest = ev_src;
            if (is_proc && st_busy(core_q.st)) begin
                core_d.p.rec_m = 1'b1;
            end else begin
                unique case (core_q.st)
                    ST_NP, ST_I: begin
                        unique case (kind)
                            EV_LOAD, EV_IFETCH, EV_STORE: begin
                                core_d.st      = (kind == EV_STORE) ? ST_IM : ST_IS;
                                core_d.p.req_v = 1'b1;
                                core_d.p.req_t = (kind == EV_LOAD) ? RQ_GETS :
                                                 (kind == EV_IFETCH) ? RQ_GETI : RQ_GETX;
                                core_d.p.alloc = 1'b1;
                                core_d.p.pop_m = 1'b1;
                                core_d.tbe     = 1'b1;
                                trk_clr        = 1'b1;
                            end
                            EV_REPL: begin
                                core_d.st     = ST_NP;
                                core_d.dirty  = 1'b0;
                                core_d.p.free = 1'b1;
                                core_d.p.pop_m = 1'b1;
                            end
                            EV_INV: begin
                                core_d.p.rsp_v     = 1'b1;
                                core_d.p.rsp_t     = RS_ACK;
                                core_d.p.rsp_to_rq = 1'b1;
                                core_d.p.pop_q     = 1'b1;
                            end
                            default: ill = 1'b1;
                        endcase
                    end
                    ST_S: begin
                        unique case (kind)
                            EV_LOAD, EV_IFETCH: begin
                                core_d.p.ld    = 1'b1;
                                core_d.p.pop_m = 1'b1;
                            end
                            EV_STORE: begin
                                core_d.st      = ST_SM;
                                core_d.p.req_v = 1'b1;
                                core_d.p.req_t = RQ_UPG;
                                core_d.p.pop_m = 1'b1;
                                core_d.tbe     = 1'b1;
                                trk_clr        = 1'b1;
                            end
                            EV_REPL: begin
                                core_d.st      = ST_I;
                                core_d.p.free  = 1'b1;
                                core_d.p.pop_m = 1'b1;
                            end
                            EV_INV: begin
                                core_d.st          = ST_I;
                                core_d.p.rsp_v     = 1'b1;
                                core_d.p.rsp_t     = RS_ACK;
                                core_d.p.rsp_to_rq = 1'b1;
                                core_d.p.pop_q     = 1'b1;
                            end
                            default: ill = 1'b1;
                        endcase
                    end
                    ST_E, ST_M: begin
                        unique case (kind)
                            EV_LOAD, EV_IFETCH: begin
                                core_d.p.ld    = 1'b1;
                                core_d.p.pop_m = 1'b1;
                            end
                            EV_STORE: begin
                                core_d.st      = ST_M;
                                core_d.dirty   = 1'b1;
                                core_d.p.st    = 1'b1;
                                core_d.p.pop_m = 1'b1;
                            end
                            EV_REPL: begin
                                core_d.st          = ST_MI;
                                core_d.p.req_v     = 1'b1;
                                core_d.p.req_t     = RQ_PUTX;
                                core_d.p.req_dirty = core_q.dirty;
                                core_d.tdirty      = core_q.dirty;
                                core_d.tbe         = 1'b1;
                                core_d.dirty       = 1'b0;
                                core_d.p.free      = 1'b1;
                                core_d.p.pop_m     = 1'b1;
                            end
                            EV_INV: begin
                                core_d.st       = ST_I;
                                core_d.dirty    = 1'b0;
                                core_d.p.rsp_v  = 1'b1;
                                core_d.p.pop_q  = 1'b1;
                                if (core_q.st == ST_M) begin
                                    core_d.p.rsp_t     = RS_DATA;
                                    core_d.p.rsp_to_l2 = 1'b1;
                                    core_d.p.rsp_dirty = core_q.dirty;
                                end else begin
                                    core_d.p.rsp_t     = RS_ACK;
                                    core_d.p.rsp_to_rq = 1'b1;
                                end
                            end
                            EV_FGETX, EV_FUPG: begin
                                core_d.st          = ST_I;
                                core_d.dirty       = 1'b0;
                                core_d.p.rsp_v     = 1'b1;
                                core_d.p.rsp_t     = RS_DATA;
                                core_d.p.rsp_to_rq = 1'b1;
                                core_d.p.rsp_dirty = core_q.dirty;
                                core_d.p.pop_q     = 1'b1;
                            end
                            EV_FGETS, EV_FGETI: begin
                                core_d.st          = ST_S;
                                core_d.p.rsp_v     = 1'b1;
                                core_d.p.rsp_t     = RS_DATA;
                                core_d.p.rsp_to_rq = 1'b1;
                                core_d.p.rsp_to_l2 = 1'b1;
                                core_d.p.rsp_dirty = core_q.dirty;
                                core_d.p.pop_q     = 1'b1;
                            end
                            default: ill = 1'b1;
                        endcase
                    end
                    ST_MI: begin
                        unique case (kind)
                            EV_WBACK: begin
                                core_d.st      = ST_I;
                                core_d.tbe     = 1'b0;
                                core_d.p.pop_r = 1'b1;
                            end
                            EV_INV, EV_FGETX, EV_FUPG, EV_FGETS, EV_FGETI: begin
                                core_d.st          = ST_SINK;
                                core_d.p.rsp_v     = 1'b1;
                                core_d.p.rsp_t     = RS_DATA;
                                core_d.p.rsp_tbe   = 1'b1;
                                core_d.p.rsp_dirty = core_q.tdirty;
                                core_d.p.rsp_to_rq = (kind != EV_INV);
                                core_d.p.rsp_to_l2 = (kind == EV_INV) ||
                                                     (kind == EV_FGETS) || (kind == EV_FGETI);
                                core_d.p.pop_q     = 1'b1;
                            end
                            default: ill = 1'b1;
                        endcase
                    end
                    ST_SINK: begin
                        unique case (kind)
                            EV_WBACK: begin
                                core_d.st      = ST_I;
                                core_d.tbe     = 1'b0;
                                core_d.p.pop_r = 1'b1;
                            end
                            EV_INV: begin
                                core_d.p.rsp_v     = 1'b1;
                                core_d.p.rsp_t     = RS_ACK;
                                core_d.p.rsp_to_rq = 1'b1;
                                core_d.p.pop_q     = 1'b1;
                            end
                            default: ill = 1'b1;
                        endcase
                    end
                    ST_IS, ST_ISI: begin
                        unique case (kind)
                            EV_INV: begin
                                core_d.st          = ST_ISI;
                                core_d.p.rsp_v     = 1'b1;
                                core_d.p.rsp_t     = RS_ACK;
                                core_d.p.rsp_to_rq = 1'b1;
                                core_d.p.pop_q     = 1'b1;
                            end
                            EV_DATA: begin
                                if (ev_from_l1 || data_all) begin
                                    trk_add        = 1'b1;
                                    core_d.st      = (core_q.st == ST_IS) ? ST_S : ST_I;
                                    core_d.dirty   = ev_dirty;
                                    core_d.tbe     = 1'b0;
                                    core_d.p.ld    = 1'b1;
                                    core_d.p.unb_v = ev_from_l1;
                                    core_d.p.pop_r = 1'b1;
                                end else begin
                                    ill = 1'b1;
                                end
                            end
                            EV_DATAX: begin
                                core_d.st      = ST_E;
                                core_d.dirty   = ev_dirty;
                                core_d.tbe     = 1'b0;
                                core_d.p.ld    = 1'b1;
                                core_d.p.unb_v = 1'b1;
                                core_d.p.unb_x = 1'b1;
                                core_d.p.pop_r = 1'b1;
                            end
                            default: ill = 1'b1;
                        endcase
                    end
                    ST_IM, ST_SM: begin
                        unique case (kind)
                            EV_INV: begin
                                core_d.st          = ST_IM;
                                core_d.p.rsp_v     = 1'b1;
                                core_d.p.rsp_t     = RS_ACK;
                                core_d.p.rsp_to_rq = 1'b1;
                                core_d.p.pop_q     = 1'b1;
                            end
                            EV_DATA: begin
                                if (core_q.st == ST_IM) begin
                                    trk_add        = 1'b1;
                                    core_d.p.pop_r = 1'b1;
                                    if (data_all) begin
                                        core_d.st      = ST_M;
                                        core_d.dirty   = 1'b1;
                                        core_d.tbe     = 1'b0;
                                        core_d.p.st    = 1'b1;
                                        core_d.p.unb_v = 1'b1;
                                        core_d.p.unb_x = 1'b1;
                                    end else begin
                                        core_d.st    = ST_SM;
                                        core_d.dirty = ev_dirty;
                                    end
                                end else begin
                                    ill = 1'b1;
                                end
                            end
                            EV_ACK: begin
                                if (ack_all && core_q.st == ST_IM) begin
                                    ill = 1'b1;
                                end else begin
                                    trk_sub        = 1'b1;
                                    core_d.p.pop_r = 1'b1;
                                    if (ack_all) begin
                                        core_d.st      = ST_M;
                                        core_d.dirty   = 1'b1;
                                        core_d.tbe     = 1'b0;
                                        core_d.p.st    = 1'b1;
                                        core_d.p.unb_v = 1'b1;
                                        core_d.p.unb_x = 1'b1;
                                    end
                                end
                            end
                            default: ill = 1'b1;
                        endcase
                    end
                    default: ill = 1'b1;
                endcase
            end
            if (ill) begin
                core_d       = core_q;
                core_d.p     = '0;
                core_d.p.err = 1'b1;
                trk_clr      = 1'b0;
                trk_add      = 1'b0;
                trk_sub      = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q    <= '0;
            core_q.st <= ST_I;
        end else begin
            core_q <= core_d;
        end
    end

    assign state        = core_q.st;
    assign perm         = perm_w;
    assign dirty        = core_q.dirty;
    assign tbe_busy     = core_q.tbe;
    assign req_valid    = core_q.p.req_v;
    assign req_type     = core_q.p.req_t;
    assign req_dirty    = core_q.p.req_dirty;
    assign req_bank     = bank;
    assign rsp_valid    = core_q.p.rsp_v;
    assign rsp_type     = core_q.p.rsp_t;
    assign rsp_to_req   = core_q.p.rsp_to_rq;
    assign rsp_dest     = core_q.dest;
    assign rsp_to_l2    = core_q.p.rsp_to_l2;
    assign rsp_bank     = bank;
    assign rsp_from_tbe = core_q.p.rsp_tbe;
    assign rsp_dirty    = core_q.p.rsp_dirty;
    assign unb_valid    = core_q.p.unb_v;
    assign unb_excl     = core_q.p.unb_x;
    assign unb_bank     = bank;
    assign pop_mand     = core_q.p.pop_m;
    assign recycle_mand = core_q.p.rec_m;
    assign pop_req      = core_q.p.pop_q;
    assign pop_rsp      = core_q.p.pop_r;
    assign ld_done      = core_q.p.ld;
    assign st_done      = core_q.p.st;
    assign line_alloc   = core_q.p.alloc;
    assign line_free    = core_q.p.free;
    assign err          = core_q.p.err;

    AST_RECYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind <= 4'd3 && st_busy(core_q.st))
        |=> (recycle_mand && !req_valid && core_q.st == $past(core_q.st))); // R3
    AST_IDLE_INV_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 4'd4 && (core_q.st == ST_NP || core_q.st == ST_I))
        |=> (rsp_valid && rsp_type == RS_ACK && core_q.st == $past(core_q.st))); // R4
    AST_SINK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_SINK && !(ev_valid && ev_kind == 4'd12))
        |=> (core_q.st == ST_SINK)); // R7
    AST_XUNB_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (unb_valid && unb_excl) |-> (core_q.st == ST_E || core_q.st == ST_M)); // R9
    AST_ERR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (core_q.st == $past(core_q.st))); // R12
    AST_ONE_QUEUE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pop_mand, recycle_mand, pop_req, pop_rsp, err})); // R12
endmodule

// File: tb/l1_line_coh_bench.sv
module l1_line_coh_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W  = 4;
    localparam int ACK_W = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic [31:0] line_addr = 32'h0000_00C0;
    logic ev_valid = 0;
    logic [3:0] ev_kind = 0;
    logic [ID_W-1:0] ev_src = 0;
    logic ev_from_l1 = 0;
    logic [ACK_W-1:0] ev_acks = 0;
    logic ev_dirty = 0;

    logic [3:0] state;
    logic [1:0] perm, req_bank, rsp_bank, unb_bank;
    logic dirty, tbe_busy, req_valid, req_dirty, rsp_valid, rsp_type, rsp_to_req;
    logic [2:0] req_type;
    logic [ID_W-1:0] rsp_dest;
    logic rsp_to_l2, rsp_from_tbe, rsp_dirty, unb_valid, unb_excl;
    logic pop_mand, recycle_mand, pop_req, pop_rsp, ld_done, st_done;
    logic line_alloc, line_free, err;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    l1_line_coh u_l1_line_coh (
        .clk(clk), .rst_n(rst_n), .line_addr(line_addr), .ev_valid(ev_valid),
        .ev_kind(ev_kind), .ev_src(ev_src), .ev_from_l1(ev_from_l1),
        .ev_acks(ev_acks), .ev_dirty(ev_dirty), .state(state), .perm(perm),
        .dirty(dirty), .tbe_busy(tbe_busy), .req_valid(req_valid),
        .req_type(req_type), .req_dirty(req_dirty), .req_bank(req_bank),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_to_req(rsp_to_req),
        .rsp_dest(rsp_dest), .rsp_to_l2(rsp_to_l2), .rsp_bank(rsp_bank),
        .rsp_from_tbe(rsp_from_tbe), .rsp_dirty(rsp_dirty),
        .unb_valid(unb_valid), .unb_excl(unb_excl), .unb_bank(unb_bank),
        .pop_mand(pop_mand), .recycle_mand(recycle_mand), .pop_req(pop_req),
        .pop_rsp(pop_rsp), .ld_done(ld_done), .st_done(st_done),
        .line_alloc(line_alloc), .line_free(line_free), .err(err)
    );

    task automatic chk(input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", r, what, act, exp);
        end
    endtask

    // drive one event for one cycle; outputs are read at the following negedge
    task automatic put(input logic [3:0] k, input logic [ID_W-1:0] src = 0,
                       input logic [ACK_W-1:0] n = 0, input logic l1 = 0,
                       input logic d = 0);
        @(negedge clk);
        ev_valid = 1; ev_kind = k; ev_src = src; ev_acks = n;
        ev_from_l1 = l1; ev_dirty = d;
        @(negedge clk);
        ev_valid = 0;
    endtask

    task automatic t_reset;
        chk("R1", "state", state, 1);
        chk("R2", "perm", perm, 0);
        chk("R1", "pulses", {req_valid, rsp_valid, unb_valid, err, pop_mand}, 0);
    endtask

    task automatic t_load_share;
        put(0);
        chk("R4", "GETS", {req_valid, req_type}, {1'b1, 3'd0});
        chk("R4", "state IS", state, 5);
        chk("R2", "busy", perm, 3);
        chk("R11", "bank", req_bank, 3);
        put(2);
        chk("R3", "recycle", {recycle_mand, req_valid, pop_mand}, 3'b100);
        chk("R3", "state held", state, 5);
        put(9, 2, 0, 0, 0);
        chk("R9", "state S", state, 2);
        chk("R9", "ld/unb", {ld_done, unb_valid, pop_rsp}, 3'b101);
        chk("R2", "ro", perm, 1);
    endtask

    task automatic t_upgrade;
        put(2);
        chk("R5", "UPGRADE", {req_valid, req_type}, {1'b1, 3'd3});
        chk("R5", "state SM", state, 7);
        put(4, 5);
        chk("R10", "inv in SM", {state, rsp_valid, rsp_type}, {4'd6, 1'b1, 1'b1});
        chk("R10", "ack dest", rsp_dest, 5);
        put(9, 0, 2);
        chk("R10", "data->SM", {state, st_done}, {4'd7, 1'b0});
        put(11);
        chk("R10", "ack1", {state, st_done, unb_valid}, {4'd7, 2'b00});
        put(11);
        chk("R10", "ack_all", {state, st_done, unb_valid, unb_excl}, {4'd4, 3'b111});
        chk("R2", "rw", perm, 2);
    endtask

    task automatic t_fwd_gets_m;
        put(5, 9);
        chk("R8", "both paths", {rsp_valid, rsp_type, rsp_to_req, rsp_to_l2, rsp_from_tbe},
            5'b10110);
        chk("R8", "dest", rsp_dest, 9);
        chk("R8", "state S", state, 2);
        chk("R11", "rsp bank", rsp_bank, 3);
    endtask

    task automatic t_ifetch_race;
        put(4, 1);
        chk("R8", "S inv -> I", {state, rsp_type}, {4'd1, 1'b1});
        put(1);
        chk("R4", "GET_INSTR", {req_valid, req_type, state}, {1'b1, 3'd1, 4'd5});
        put(4, 3);
        chk("R9", "IS_I", {state, rsp_valid, rsp_type}, {4'd8, 2'b11});
        put(9, 6, 0, 1, 0);
        chk("R9", "l1 data in IS_I", {state, ld_done, unb_valid, unb_excl}, {4'd1, 3'b110});
    endtask

    task automatic t_excl_writeback;
        put(0);
        put(10, 0, 0, 0, 0);
        chk("R9", "excl", {state, ld_done, unb_valid, unb_excl}, {4'd3, 3'b111});
        chk("R11", "unb bank", unb_bank, 3);
        put(2);
        chk("R5", "silent E->M", {state, req_valid, st_done, dirty}, {4'd4, 3'b011});
        put(3);
        chk("R6", "PUTX", {req_valid, req_type, req_dirty}, {1'b1, 3'd4, 1'b1});
        chk("R6", "M_I free", {state, line_free}, {4'd9, 1'b1});
        put(0);
        chk("R3", "recycle in M_I", {recycle_mand, state}, {1'b1, 4'd9});
        put(6, 7);
        chk("R7", "M_I fwd read", {rsp_to_req, rsp_to_l2, rsp_from_tbe, rsp_dirty}, 4'b1111);
        chk("R7", "SINK", state, 11);
        put(2);
        chk("R3", "recycle in SINK", {recycle_mand, req_valid}, 2'b10);
        put(4, 2);
        chk("R7", "SINK inv ack", {state, rsp_type, pop_req}, {4'd11, 2'b11});
        put(12);
        chk("R7", "SINK exit", {state, pop_rsp}, {4'd1, 1'b1});
    endtask

    task automatic t_clean_wb;
        line_addr = 32'h0000_0040;
        put(0);
        chk("R11", "bank 1", req_bank, 1);
        put(10);
        put(3);
        chk("R6", "clean PUTX", {req_type, req_dirty, state}, {3'd4, 1'b0, 4'd9});
        put(12);
        chk("R6", "WB ack", state, 1);
    endtask

    task automatic t_fwd_getx;
        put(0);
        put(10);
        put(7, 4);
        chk("R8", "E fwd GETX", {state, rsp_to_req, rsp_to_l2}, {4'd1, 2'b10});
        put(0);
        put(10);
        put(3);
        put(8, 8);
        chk("R7", "M_I upgrade fwd", {state, rsp_to_req, rsp_to_l2, rsp_from_tbe},
            {4'd11, 3'b101});
        put(12);
    endtask

    task automatic t_acks_first;
        put(2);
        chk("R4", "GETX", {req_type, state}, {3'd2, 4'd6});
        put(11);
        chk("R10", "early ack", {state, err, pop_rsp}, {4'd6, 2'b01});
        put(9, 0, 1);
        chk("R10", "data settles", {state, st_done, unb_excl}, {4'd4, 2'b11});
    endtask

    task automatic t_illegal;
        put(4);
        put(12);
        chk("R12", "err I", {err, state, pop_rsp, pop_req}, {1'b1, 4'd1, 2'b00});
        put(0);
        put(9);
        put(5);
        chk("R12", "err S", {err, state, rsp_valid}, {1'b1, 4'd2, 1'b0});
        put(3);
        put(3);
        chk("R4", "repl in I", {state, line_free}, {4'd0, 1'b1});
        put(4);
        chk("R4", "NP inv", {state, rsp_type, rsp_valid}, {4'd0, 2'b11});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_load_share();
        t_upgrade();
        t_fwd_gets_m();
        t_ifetch_race();
        t_excl_writeback();
        t_clean_wb();
        t_fwd_getx();
        t_acks_first();
        t_illegal();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule